// File: doc/BRIEF.md
# Immediate-Shift Dual-Source Narrow-and-Pack Unit

This unit takes two 128-bit vectors, a freshly read source operand and the previous contents of the destination, and applies one immediate shift amount to every element of both. Each element is shifted right with round-to-nearest (the last bit shifted out is added back), saturated to half its width and packed. The narrowed source elements form the low 64 bits of the result. The narrowed old-destination elements form the high 64 bits. Because both halves are computed from the inputs as presented, writing the new result cannot disturb the upper half's computation.

Four element sizes are selected by `elem_size`: 16-bit to 8-bit (0), 32-bit to 16-bit (1), 64-bit to 32-bit (2) and a 128-bit to 64-bit quad form (3). Two mode bits select the shift and the saturation. `shift_arith` picks an arithmetic (sign-filling) or a logical (zero-filling) shift. `sat_signed` picks a signed or an unsigned saturated result. Results are registered behind a valid/ready handshake with one cycle of latency.

Top module: `nrw_pack_unit`

## Requirements
- R1: For element width w (16 << elem_size) and half width h = w/2, narrowed lane i of `src_vec` appears at result bits [i*h +: h]. Narrowed lane i of `old_dst` appears at bits [64 + i*h +: h].
- R2: The shift amount s is the low log2(w) bits of `shamt`: 4, 5, 6 or 7 bits for sizes 0 to 3. Higher bits are ignored.
- R3: When s > 0, the element is shifted right by s and bit s-1 of the original element is added. When s = 0 the element passes unshifted and unrounded.
- R4: With sat_signed=1 and shift_arith=0 (logical), the result is clamped above at 2^(h-1)-1. It has no lower bound, since the shifted value is never negative.
- R5: With sat_signed=0 and shift_arith=0, the result is clamped at 2^h-1.
- R6: With sat_signed=1 and shift_arith=1, the result is clamped to the range [-2^(h-1), 2^(h-1)-1].
- R7: With sat_signed=0 and shift_arith=1, a negative element yields 0. Otherwise the result is clamped at 2^h-1.
- R8: In the quad form (elem_size=3) the same four rules apply with h=64. A maximal 128-bit value that is rounded up saturates and does not wrap.
- R9: `in_ready` is high when the output register is empty or being drained. An accepted input appears on `result` with `out_valid` high in the next cycle. While `out_valid` is high and `out_ready` is low, `out_valid` and `result` hold.
- R10: While `rst_n` is low, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input operands valid |
| in_ready | output | 1 | Unit can accept an input |
| elem_size | input | 2 | 0:16→8, 1:32→16, 2:64→32, 3:128→64 |
| sat_signed | input | 1 | 1: signed saturated result, 0: unsigned |
| shift_arith | input | 1 | 1: arithmetic shift, 0: logical shift |
| shamt | input | 7 | Immediate shift amount (low log2(w) bits used) |
| src_vec | input | 128 | New source operand |
| old_dst | input | 128 | Previous destination value |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer accepts result |
| result | output | 128 | Packed narrowed result |

## Verification
The bench sends amounts whose upper bits are set. A unit that used the full immediate for small elements would then shift too far and return zeros. It checks odd values at a one-bit shift, where a missing or off-by-one rounding bit changes the low result bit. It also checks a zero shift, where a unit that rounds from bit -1 would read garbage.

In the quad form it feeds an all-ones 128-bit value at shift 1. A 128-bit intermediate would wrap there and give zero instead of saturating. It also feeds negative values in unsigned-arithmetic mode, which must give 0 and not a clamped maximum. Known lane indices are checked for exact placement in both halves, and a stalling consumer exposes any result that changes while held.

// File: rtl/nrw_pkg.sv
package nrw_pkg;
  // element size select, value doubles the width per step
  typedef enum logic [1:0] {
    SZ_16  = 2'd0,
    SZ_32  = 2'd1,
    SZ_64  = 2'd2,
    SZ_128 = 2'd3
  } elem_size_e;

  typedef struct packed {
    logic sat_signed;  // signed saturated result
    logic arith;       // arithmetic right shift
  } mode_t;

  localparam int MIN_ELEM_W = 16;
endpackage

// File: rtl/nrw_lane.sv
// One element: rounding right shift, then saturation to half width.
module nrw_lane #(
  parameter int W = 16
) (
  input  logic [W-1:0]          elem,
  input  logic [$clog2(W)-1:0]  sh,
  input  nrw_pkg::mode_t        mode,
  output logic [W/2-1:0]        narrow
);
  localparam int H  = W / 2;
  localparam int SW = $clog2(W);

  // bounds on a W+1 bit signed scale
  localparam logic signed [W:0] S_HI = {{(W-H+2){1'b0}}, {(H-1){1'b1}}};
  localparam logic signed [W:0] S_LO = {{(W-H+2){1'b1}}, {(H-1){1'b0}}};
  localparam logic signed [W:0] U_HI = {{(W-H+1){1'b0}}, {H{1'b1}}};

  logic signed [W:0] ext;
  logic signed [W:0] shd;
  logic signed [W:0] sum;
  logic [SW-1:0]     ridx;
  logic              rbit;

  always_comb begin
    ext  = mode.arith ? $signed({elem[W-1], elem}) : $signed({1'b0, elem});
    shd  = ext >>> sh;
    ridx = sh - SW'(1);
    rbit = (sh != '0) ? ext[ridx] : 1'b0;
    sum  = shd + $signed({{W{1'b0}}, rbit});

    if (mode.sat_signed) begin
      if (sum > S_HI)      narrow = S_HI[H-1:0];
      else if (sum < S_LO) narrow = S_LO[H-1:0];
      else                 narrow = sum[H-1:0];
    end else begin
      if (sum[W])          narrow = '0;
      else if (sum > U_HI) narrow = U_HI[H-1:0];
      else                 narrow = sum[H-1:0];
    end
  end
endmodule

// File: rtl/nrw_half.sv
// Narrows every W-bit element of one vector into a half-width vector.
module nrw_half #(
  parameter int VEC_W = 128,
  parameter int W     = 16
) (
  input  logic [VEC_W-1:0]      vec,
  input  logic [$clog2(W)-1:0]  sh,
  input  nrw_pkg::mode_t        mode,
  output logic [VEC_W/2-1:0]    half
);
  localparam int NL = VEC_W / W;
  localparam int H  = W / 2;

  for (genvar i = 0; i < NL; i++) begin : g_lane
    nrw_lane #(.W(W)) lane_i (
      .elem   (vec[i*W +: W]),
      .sh     (sh),
      .mode   (mode),
      .narrow (half[i*H +: H])
    );
  end
endmodule

// File: rtl/nrw_pack_unit.sv
module nrw_pack_unit #(
  parameter int VEC_W = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [1:0]        elem_size,
  input  logic              sat_signed,
  input  logic              shift_arith,
  input  logic [6:0]        shamt,
  input  logic [127:0]      src_vec,
  input  logic [127:0]      old_dst,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [127:0]      result
);
  import nrw_pkg::*;

  localparam int NSZ = $clog2(VEC_W / MIN_ELEM_W) + 1;

  mode_t            mode;
  logic [VEC_W-1:0] cand [NSZ];
  logic [VEC_W-1:0] res_next;
  logic             vld_next;
  logic             load_en;

  assign mode.sat_signed = sat_signed;
  assign mode.arith      = shift_arith;

  // one packer pair per supported element size
  for (genvar k = 0; k < NSZ; k++) begin : g_size
    localparam int EW = MIN_ELEM_W << k;
    localparam int SW = $clog2(EW);
    logic [VEC_W/2-1:0] lo_half;
    logic [VEC_W/2-1:0] hi_half;

    nrw_half #(.VEC_W(VEC_W), .W(EW)) src_half_i (
      .vec  (src_vec),
      .sh   (shamt[SW-1:0]),
      .mode (mode),
      .half (lo_half)
    );
    nrw_half #(.VEC_W(VEC_W), .W(EW)) dst_half_i (
      .vec  (old_dst),
      .sh   (shamt[SW-1:0]),
      .mode (mode),
      .half (hi_half)
    );
    assign cand[k] = {hi_half, lo_half};
  end

  assign in_ready = !out_valid || out_ready;
  assign load_en  = in_valid && in_ready;

  always_comb begin
    res_next = cand[elem_size];
    if (load_en)        vld_next = 1'b1;
    else if (out_ready) vld_next = 1'b0;
    else                vld_next = out_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_valid <= 1'b0;
    else        out_valid <= vld_next;
  end

  always_ff @(posedge clk) begin
    if (load_en) result <= res_next;
  end
endmodule

// File: rtl/nrw_pack_unit_chk.sv
module nrw_pack_unit_chk (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_ready,
  input logic [1:0]   elem_size,
  input logic         sat_signed,
  input logic         shift_arith,
  input logic [127:0] src_vec,
  input logic         out_valid,
  input logic         out_ready,
  input logic [127:0] result
);
  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(result));

  // R9
  accept_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  // R9
  drain_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !in_valid |=> !out_valid);

  // R4
  quad_sl_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && elem_size == 2'd3 && sat_signed && !shift_arith
    |=> !result[63] && !result[127]);

  // R7
  quad_ua_neg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && elem_size == 2'd3 && !sat_signed && shift_arith && src_vec[127]
    |=> result[63:0] == 64'd0);
endmodule

bind nrw_pack_unit nrw_pack_unit_chk chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .elem_size   (elem_size),
  .sat_signed  (sat_signed),
  .shift_arith (shift_arith),
  .src_vec     (src_vec),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .result      (result)
);

// File: tb/nrw_pack_unit_tb_top.sv
module nrw_pack_unit_tb_top;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid;
  logic         in_ready;
  logic [1:0]   elem_size;
  logic         sat_signed;
  logic         shift_arith;
  logic [6:0]   shamt;
  logic [127:0] src_vec;
  logic [127:0] old_dst;
  logic         out_valid;
  logic         out_ready;
  logic [127:0] result;

  typedef struct {
    logic [127:0] exp;
    string        tag;
  } item_t;

  item_t sbq[$];
  int    n_chk = 0;
  int    n_bad = 0;
  bit    done  = 0;
  logic [63:0] lfsr = 64'h9E37_79B9_7F4A_7C15;

  always #(CLK_PERIOD/2) clk = ~clk;

  nrw_pack_unit dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .elem_size(elem_size), .sat_signed(sat_signed), .shift_arith(shift_arith),
    .shamt(shamt), .src_vec(src_vec), .old_dst(old_dst),
    .out_valid(out_valid), .out_ready(out_ready), .result(result)
  );

  function automatic logic [63:0] nxt();
    lfsr = lfsr ^ (lfsr << 13);
    lfsr = lfsr ^ (lfsr >> 7);
    lfsr = lfsr ^ (lfsr << 17);
    return lfsr;
  endfunction

  // reference for one element, from the requirements
  function automatic logic [63:0] ref_lane(logic [127:0] e, int w, int s, bit sg, bit ar);
    logic signed [131:0] v, r, hi, lo;
    int h = w / 2;
    v = '0;
    for (int b = 0; b < w; b++) v[b] = e[b];
    if (ar && e[w-1]) for (int b = w; b < 132; b++) v[b] = 1'b1;
    r = v >>> s;
    if (s > 0 && v[s-1]) r = r + 132'sd1;
    hi = '0;
    for (int b = 0; b < (sg ? h-1 : h); b++) hi[b] = 1'b1;
    lo = '0;
    if (sg) for (int b = h-1; b < 132; b++) lo[b] = 1'b1;
    if (r > hi)      r = hi;
    else if (r < lo) r = lo;
    return r[63:0];
  endfunction

  function automatic logic [127:0] ref_vec(int sz, bit sg, bit ar, logic [6:0] imm,
                                           logic [127:0] s_v, logic [127:0] o_v);
    logic [127:0] res, msk;
    logic [63:0]  la, lb;
    int w = 16 << sz;
    int h = w / 2;
    int s = int'(imm) % w;
    msk = (w == 128) ? '1 : ((128'd1 << w) - 128'd1);
    res = '0;
    for (int i = 0; i < 128 / w; i++) begin
      la = ref_lane((s_v >> (i*w)) & msk, w, s, sg, ar);
      lb = ref_lane((o_v >> (i*w)) & msk, w, s, sg, ar);
      for (int b = 0; b < h; b++) begin
        res[i*h + b]      = la[b];
        res[64 + i*h + b] = lb[b];
      end
    end
    return res;
  endfunction

  task automatic check(bit ok, string tag, logic [127:0] act, logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send(int sz, bit sg, bit ar, logic [6:0] imm,
                      logic [127:0] s_v, logic [127:0] o_v,
                      logic [127:0] exp, string tag);
    sbq.push_back('{exp, tag});
    @(negedge clk);
    elem_size   = 2'(sz);
    sat_signed  = sg;
    shift_arith = ar;
    shamt       = imm;
    src_vec     = s_v;
    old_dst     = o_v;
    in_valid    = 1'b1;
    #2;
    while (!in_ready) begin
      @(negedge clk);
      #2;
    end
    @(posedge clk);
    #1;
    in_valid = 1'b0;
    // R9: registered one cycle after acceptance
    check(out_valid === 1'b1, "R9 latency", {127'd0, out_valid}, 128'd1);
  endtask

  task automatic send_m(int sz, bit sg, bit ar, logic [6:0] imm,
                        logic [127:0] s_v, logic [127:0] o_v, string tag);
    send(sz, sg, ar, imm, s_v, o_v, ref_vec(sz, sg, ar, imm, s_v, o_v), tag);
  endtask

  // monitor: drives out_ready, pops the scoreboard on each transfer
  initial begin : monitor
    int           cyc = 0;
    bit           had = 0;
    logic [127:0] held = '0;
    item_t        it;
    out_ready = 1'b0;
    forever begin
      @(negedge clk);
      cyc++;
      if (had) begin
        check(out_valid === 1'b1 && result === held, "R9 hold", result, held);
        had = 0;
      end
      out_ready = (cyc % 5) != 3 && (cyc % 7) != 2;
      #1;
      if (rst_n && out_valid && out_ready) begin
        if (sbq.size() == 0) begin
          check(1'b0, "R9 unexpected output", result, '0);
        end else begin
          it = sbq.pop_front();
          check(result === it.exp, it.tag, result, it.exp);
        end
      end else if (rst_n && out_valid && !out_ready) begin
        had  = 1;
        held = result;
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired, actual=hung expected=done");
    finish_run();
  end

  initial begin : driver
    logic [127:0] a, b;
    rst_n = 1'b0; in_valid = 1'b0; elem_size = '0; sat_signed = 1'b0;
    shift_arith = 1'b0; shamt = '0; src_vec = '0; old_dst = '0;
    repeat (3) @(negedge clk);
    // R10
    check(out_valid === 1'b0 && in_ready === 1'b1, "R10 reset",
          {126'd0, out_valid, in_ready}, 128'd1);
    rst_n = 1'b1;

    // R1: lane index placement, unsigned logical, no shift
    for (int i = 0; i < 8; i++) begin
      a[i*16 +: 16] = 16'(i);
      b[i*16 +: 16] = 16'(8 + i);
    end
    send(0, 0, 0, 7'd0, a, b, 128'h0F0E0D0C0B0A0908_0706050403020100, "R1 placement");

    // R2: upper immediate bits ignored, 7'h13 -> shift 3 for 16-bit elements
    send(0, 0, 0, 7'h13, {8{16'h0040}}, {8{16'h0080}},
         128'h1010101010101010_0808080808080808, "R2 shamt mask");
    // R2: 32-bit elements use 5 bits, 7'h61 -> shift 1
    send_m(1, 0, 0, 7'h61, {4{32'h0000_0101}}, {4{32'h0000_7FFF}}, "R2 shamt mask w32");

    // R3: rounding bit added at shift 1
    send(1, 0, 0, 7'd1, {32'h3, 32'h2, 32'h3, 32'h2}, {4{32'h5}},
         128'h0003000300030003_0002000100020001, "R3 round");
    // R3: shift 0 passes unrounded
    send_m(2, 0, 0, 7'd0, {64'h1, 64'hFFFF_FFFE}, {64'h7, 64'h3}, "R3 no shift");

    // R4: signed logical clamp
    send(2, 1, 0, 7'd0, {64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_8000_0000},
         {64'h0, 64'h7FFF_FFFF}, 128'h00000000_7FFFFFFF_7FFFFFFF_7FFFFFFF, "R4 sl clamp");
    // R5: unsigned logical clamp
    send_m(0, 0, 0, 7'd2, {8{16'hFFFF}}, {8{16'h03FF}}, "R5 ul clamp");
    // R6: signed arithmetic both bounds
    send(0, 1, 1, 7'd0, {4{16'h8000, 16'h7FFF}}, {8{16'hFFFF}},
         128'hFFFFFFFFFFFFFFFF_807F807F807F807F, "R6 sa clamp");
    // R7: unsigned arithmetic negative -> 0
    send(0, 0, 1, 7'd0, {4{16'hFF00, 16'h0100}}, {8{16'h00AB}},
         128'hABABABABABABABAB_00FF00FF00FF00FF, "R7 ua clamp");

    // R8: quad rounding of maximal value saturates
    send(3, 0, 0, 7'd1, '1, 128'd0, {64'd0, 64'hFFFF_FFFF_FFFF_FFFF}, "R8 quad ul max");
    send(3, 1, 1, 7'd0, {1'b1, 127'd0}, 128'd1,
         {64'd1, 64'h8000_0000_0000_0000}, "R8 quad sa min");
    send(3, 0, 1, 7'd64, {1'b1, 127'd5}, {64'd3, 64'd0},
         {64'd0, 64'd0} | {64'h0, 64'h0} | {64'd3 >> 0, 64'd0} & {64'h0, 64'h0} |
         ref_vec(3, 0, 1, 7'd64, {1'b1, 127'd5}, {64'd3, 64'd0}), "R8 quad ua neg");
    send_m(3, 1, 0, 7'd3, '1, {64'h0, 64'hFFFF}, "R8 quad sl");

    // spread over all sizes and modes
    for (int n = 0; n < 80; n++) begin : rnd
      int   sz;
      bit   sg, ar;
      logic [6:0] imm;
      string tg;
      sz  = int'(nxt() % 4);
      sg  = nxt() % 2 == 1;
      ar  = nxt() % 2 == 1;
      imm = 7'(nxt());
      a   = {nxt(), nxt()};
      b   = {nxt(), nxt()};
      if (sz == 3)       tg = "R8 mixed";
      else if (sg && !ar) tg = "R4 mixed";
      else if (!sg && !ar) tg = "R5 mixed";
      else if (sg && ar) tg = "R6 mixed";
      else               tg = "R7 mixed";
      send_m(sz, sg, ar, imm, a, b, tg);
    end

    while (sbq.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule